// File: doc/BRIEF.md
# Automatic Sliding Door Controller

This block sequences an automatic sliding door through four phases: shut, opening, held open and closing. Each clock it samples seven clean, already synchronized inputs: a key lock, an obstruction force sensor that reads high at 15 lb or more, an approach sensor, a presence sensor, a manual open request, a fully-closed limit switch and a fully-open limit switch. From these it drives three outputs: a bolt, a close-motor request and an open-motor request.

Some outputs depend on the phase alone. The open request is always on while opening, and the close request is always on while closing. Other outputs also depend on the inputs of the current cycle. Examples are the bolt while locked, the close request in the shut phase until the closed limit is reached, and the open request in the held phase until the open limit is reached. The three motion inputs (approach, presence, manual) are merged into one "somebody wants through" term, called want. The want term or an obstruction reverses a closing door back into opening. The phases have the fixed two-bit codes shut=00, opening=01, held=11 and closing=10. The outputs are combinational from the registered phase and the current inputs.

Top module: `door_ctrl`

## Requirements
- R1: A low `rst_n` at a rising clock edge puts the controller in the shut phase, whatever the other inputs are. After reset, with the door unlocked, no want and the closed limit inactive, only `close_req` is high.
- R2: In shut with `key_locked` high, the phase stays shut, `bolt` is 1 and both motor requests are 0.
- R3: In shut with `key_locked` low and want high (want = approach OR presence OR manual_open), the next phase is opening and all outputs are 0 in that cycle.
- R4: In shut with `key_locked` low and want low, the phase stays shut and `close_req` equals NOT `at_closed`. `bolt` and `open_req` are 0.
- R5: In opening, `open_req` is 1 and the other outputs are 0. The next phase is held when `at_open` is high, and opening otherwise.
- R6: In held, `open_req` equals NOT `at_open` and the other outputs are 0. The phase stays held while want is high and moves to closing when want is low.
- R7: In closing, `close_req` is 1 and the other outputs are 0. When want is high or `force_high` is high, the next phase is opening.
- R8: In closing with want low and `force_high` low, the next phase is shut when `at_closed` is high, and closing otherwise.
- R9: `open_req` and `close_req` are never high together, and `bolt` is high only in the shut phase.
- R10: For every phase and every one of the 128 input combinations, exactly one next phase results, and it is the one that R2 to R8 give.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| key_locked | input | 1 | 1 = door locked by key |
| force_high | input | 1 | 1 = door resistance at or above 15 lb |
| approach | input | 1 | 1 = person or object approaching |
| presence | input | 1 | 1 = person or object in the doorway |
| manual_open | input | 1 | 1 = manual open button pressed |
| at_closed | input | 1 | 1 = door fully closed |
| at_open | input | 1 | 1 = door fully open |
| bolt | output | 1 | 1 = bolt engaged |
| close_req | output | 1 | 1 = drive door closed |
| open_req | output | 1 | 1 = drive door open |

## Verification
The phase register is not visible at the ports, so the hard part is to check every phase against all 128 input combinations and read the next phase back. The bench reaches each phase by a short directed walk from reset: release, open, reach the open limit, drop want. It then applies one combination, checks the combinational outputs and clocks once. After that it applies a probe pattern: locked, open limit high, everything else low. With this pattern each phase gives a distinct output signature (bolt only, open only, nothing, close only), and no clock edge is used to read it.

// File: rtl/door_pkg.sv
// Package: shared phase type and the merged motion term for the door controller.
// Assumes all sensor inputs are clean, synchronized logic levels.
package door_pkg;

    // Phase codes are fixed; the two-bit values are part of the block's contract.
    typedef enum logic [1:0] {
        PH_SHUT    = 2'b00,
        PH_OPENING = 2'b01,
        PH_HELD    = 2'b11,
        PH_CLOSING = 2'b10
    } door_phase_e;

    localparam int PHASE_W = $bits(door_phase_e);

    // Somebody wants through: approach, presence or manual request.
    function automatic logic want_through(input logic appr, input logic pres, input logic man);
        return appr | pres | man;
    endfunction

endpackage

// File: rtl/door_next_phase.sv
// Module: next-phase logic. Purely combinational; picks exactly one successor
// for the current phase from the lock, merged want term, force and limit inputs.
// Assumes the inputs are stable within the cycle.
module door_next_phase
    import door_pkg::*;
(
    input  door_phase_e cur,
    input  logic        locked,
    input  logic        want,
    input  logic        force_hi,
    input  logic        lim_closed,
    input  logic        lim_open,
    output door_phase_e nxt
);

    // Successor selection; each branch covers its phase's full input space.
    always_comb begin
        nxt = cur;
        unique case (cur)
            PH_SHUT:    nxt = (!locked && want) ? PH_OPENING : PH_SHUT;
            PH_OPENING: nxt = lim_open ? PH_HELD : PH_OPENING;
            PH_HELD:    nxt = want ? PH_HELD : PH_CLOSING;
            PH_CLOSING: begin
                if (want || force_hi)
                    nxt = PH_OPENING;
                else if (lim_closed)
                    nxt = PH_SHUT;
                else
                    nxt = PH_CLOSING;
            end
            default:    nxt = PH_SHUT;
        endcase
    end

endmodule

// File: rtl/door_out_decode.sv
// Module: output decode. Per-phase outputs combined with outputs that also
// depend on the current lock, want and limit inputs.
// Assumes outputs default to 0 unless a phase asserts them.
module door_out_decode
    import door_pkg::*;
(
    input  door_phase_e cur,
    input  logic        locked,
    input  logic        want,
    input  logic        lim_closed,
    input  logic        lim_open,
    output logic        bolt_o,
    output logic        close_o,
    output logic        open_o
);

    // Output selection by phase with input-qualified actions.
    always_comb begin
        bolt_o  = 1'b0;
        close_o = 1'b0;
        open_o  = 1'b0;
        unique case (cur)
            PH_SHUT: begin
                bolt_o  = locked;
                close_o = !locked && !want && !lim_closed;
            end
            PH_OPENING: open_o  = 1'b1;
            PH_HELD:    open_o  = !lim_open;
            PH_CLOSING: close_o = 1'b1;
            default: ;
        endcase
    end

    // Motor directions must never fight (R9).
    always_comb begin
        p_no_fight_r9: assert (!(open_o && close_o));
    end

endmodule

// File: rtl/door_phase_reg.sv
// Module: phase register. Rising-edge flops with synchronous active-low reset
// to the shut phase.
module door_phase_reg
    import door_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  door_phase_e nxt,
    output door_phase_e cur
);

    // Hold the phase; reset wins over any successor.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur <= PH_SHUT;
        else
            cur <= nxt;
    end

endmodule

// File: rtl/door_ctrl.sv
// Module: top of the sliding door controller. Merges the motion inputs,
// registers the phase and decodes the outputs combinationally.
// Assumes synchronized inputs and a synchronous active-low reset.
module door_ctrl
    import door_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_locked,
    input  logic force_high,
    input  logic approach,
    input  logic presence,
    input  logic manual_open,
    input  logic at_closed,
    input  logic at_open,
    output logic bolt,
    output logic close_req,
    output logic open_req
);

    door_phase_e phase_q;
    door_phase_e phase_d;
    logic        want;

    // Single shared copy of the motion term.
    always_comb want = want_through(approach, presence, manual_open);

    door_next_phase u_next (
        .cur        (phase_q),
        .locked     (key_locked),
        .want       (want),
        .force_hi   (force_high),
        .lim_closed (at_closed),
        .lim_open   (at_open),
        .nxt        (phase_d)
    );

    door_phase_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (phase_d),
        .cur   (phase_q)
    );

    door_out_decode u_out (
        .cur        (phase_q),
        .locked     (key_locked),
        .want       (want),
        .lim_closed (at_closed),
        .lim_open   (at_open),
        .bolt_o     (bolt),
        .close_o    (close_req),
        .open_o     (open_req)
    );

    // Reset lands in shut on the first released cycle.
    p_reset_shut_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> phase_q == PH_SHUT);

    // A locked shut door stays shut.
    p_lock_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SHUT && key_locked) |=> phase_q == PH_SHUT);

    // Unlocked with want leaves shut for opening.
    p_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SHUT && !key_locked && want) |=> phase_q == PH_OPENING);

    // Reaching the open limit finishes the opening.
    p_open_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_OPENING && at_open) |=> phase_q == PH_HELD);

    // Held door starts closing once nobody wants through.
    p_held_leave_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HELD && !want) |=> phase_q == PH_CLOSING);

    // Want or obstruction reverses a closing door.
    p_reverse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CLOSING && (want || force_high)) |=> phase_q == PH_OPENING);

    // Clear path plus closed limit ends the closing.
    p_arrive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CLOSING && !want && !force_high && at_closed) |=> phase_q == PH_SHUT);

    // Bolt only ever in shut.
    p_bolt_shut_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bolt |-> phase_q == PH_SHUT);

endmodule

// File: tb/door_ctrl_bench.sv
// Directed bench: reset tasks plus an exhaustive per-phase sweep.
module door_ctrl_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic key_locked = 0, force_high = 0, approach = 0, presence = 0;
    logic manual_open = 0, at_closed = 0, at_open = 0;
    logic bolt, close_req, open_req;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    door_ctrl u_door_ctrl (
        .clk(clk), .rst_n(rst_n), .key_locked(key_locked), .force_high(force_high),
        .approach(approach), .presence(presence), .manual_open(manual_open),
        .at_closed(at_closed), .at_open(at_open),
        .bolt(bolt), .close_req(close_req), .open_req(open_req)
    );

    // Bench phase labels: 0 shut, 1 opening, 2 held, 3 closing.
    function automatic int model_next(int ph, logic [6:0] p);
        logic lk, fh, w, cl, op;
        lk = p[6]; fh = p[5]; w = p[4] | p[3] | p[2]; cl = p[1]; op = p[0];
        case (ph)
            0: return (!lk && w) ? 1 : 0;
            1: return op ? 2 : 1;
            2: return w ? 2 : 3;
            default: return (w || fh) ? 1 : (cl ? 0 : 3);
        endcase
    endfunction

    // Expected {bolt, close, open}.
    function automatic logic [2:0] model_out(int ph, logic [6:0] p);
        logic lk, w, cl, op;
        lk = p[6]; w = p[4] | p[3] | p[2]; cl = p[1]; op = p[0];
        case (ph)
            0: return {lk, !lk && !w && !cl, 1'b0};
            1: return 3'b001;
            2: return {2'b00, !op};
            default: return 3'b010;
        endcase
    endfunction

    function automatic string out_tag(int ph, logic [6:0] p);
        case (ph)
            0: return p[6] ? "R2" : ((p[4] | p[3] | p[2]) ? "R3" : "R4");
            1: return "R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic string nxt_tag(int ph, logic [6:0] p);
        if (ph == 3 && !(p[5] | p[4] | p[3] | p[2])) return "R10 R8";
        return {"R10 ", out_tag(ph, p)};
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(logic [6:0] p);
        {key_locked, force_high, approach, presence, manual_open, at_closed, at_open} = p;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // Probe pattern: locked, open limit high; gives a distinct signature per phase.
    task automatic probe(output int ph);
        drive(7'b1000001);
        case ({bolt, close_req, open_req})
            3'b100: ph = 0;
            3'b001: ph = 1;
            3'b000: ph = 2;
            3'b010: ph = 3;
            default: ph = -1;
        endcase
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
    endtask

    task automatic reach(int ph);
        do_reset();
        if (ph >= 1) begin drive(7'b0010000); tick(); end
        if (ph >= 2) begin drive(7'b0000001); tick(); end
        if (ph >= 3) begin drive(7'b0000001); tick(); end
    endtask

    // R1: reset state and observable outputs after release.
    task automatic t_reset_state();
        int ph;
        do_reset();
        drive(7'b0000000);
        check({bolt, close_req, open_req} == 3'b010, "R1 outputs after reset",
              {bolt, close_req, open_req}, 3'b010);
        probe(ph);
        check(ph == 0, "R1 phase after reset", ph, 0);
    endtask

    // R1: reset beats active inputs while closing.
    task automatic t_reset_priority();
        int ph;
        reach(3);
        check(close_req == 1'b1, "R7 reached closing", close_req, 1);
        drive(7'b0111100);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        probe(ph);
        check(ph == 0, "R1 reset overrides want and force", ph, 0);
    endtask

    // R2..R10: every phase against all input combinations.
    task automatic t_sweep(int ph);
        int got;
        logic [2:0] eo;
        for (int p = 0; p < 128; p++) begin
            reach(ph);
            drive(p[6:0]);
            eo = model_out(ph, p[6:0]);
            check({bolt, close_req, open_req} == eo, out_tag(ph, p[6:0]),
                  {bolt, close_req, open_req}, eo);
            check(!(open_req && close_req), "R9 both motors", {close_req, open_req}, 0);
            check(!bolt || ph == 0, "R9 bolt outside shut", bolt, 0);
            tick();
            probe(got);
            check(got == model_next(ph, p[6:0]), nxt_tag(ph, p[6:0]),
                  got, model_next(ph, p[6:0]));
        end
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #3;
        t_reset_state();
        t_reset_priority();
        for (int s = 0; s < 4; s++) t_sweep(s);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule